// File: doc/BRIEF.md
# Solid Rectangle Fill Engine

This block is a command-driven fill engine. It writes one 32-bit value into every pixel of a destination rectangle. It is used to clear colour, depth and stencil surfaces. A six-word packet arrives on a 32-bit valid/ready word stream. The engine then walks the rectangle in row-major order and issues one byte-masked write per pixel on a valid/ready memory write port. A one-cycle `done` pulse marks the end of the packet's work. Clipping and conversion of the clear colour into the surface format are done before the packet is built.

Pixels are either 2 or 4 bytes wide. In 4-byte mode the top byte and the low three bytes of each pixel have separate enables. A packed depth/stencil surface can therefore have only its stencil byte or only its depth bits cleared. For a packed depth/stencil clear, the fill value carries the 8-bit stencil in bits 31:24 and the depth in the low bits. In 2-byte mode only the low half of the fill value is used, and both bytes of the pixel are always written.

The packet words, in arrival order, are:

1. Command: bit 0 enables the low-24-bit lanes, bit 1 enables the top-byte lane, bit 2 marks a tiled destination. The other bits are ignored.
2. Control: bits 15:0 hold the pitch; bits 23:16 hold the raster operation; bit 25 selects 4-byte pixels when set and 2-byte pixels when clear.
3. Top-left corner: y in bits 31:16, x in bits 15:0.
4. Exclusive bottom-right corner, in the same layout as word 3.
5. Destination base byte address.
6. Fill value.

Top module: `rect_fill_engine`

## Requirements
- R1: `in_ready` is low from the cycle after the sixth packet word is accepted until the `done` cycle, inclusive. It is high again in the cycle after `done`, and it is never high while `wr_valid` is high.
- R2: Exactly one write is issued per pixel. The order is x rising within a row, then rows by rising y, from (x1,y1) up to but excluding x2 and y2.
- R3: A pixel's byte address is base + y*pitch_bytes + x*pixel_bytes (modulo 2^ADDR_W). `wr_addr` is that address with its two low bits cleared.
- R4: When command bit 2 (tiled) is set, pitch_bytes is the pitch field times 4. Otherwise pitch_bytes equals the pitch field.
- R5: In 4-byte mode, `wr_data` is the fill value. `wr_be[2:0]` equals command bit 0 on all three lanes, and `wr_be[3]` equals command bit 1.
- R6: In 2-byte mode, `wr_data` is the fill value's low 16 bits repeated in both halves. `wr_be` is 4'b1100 when byte-address bit 1 is set, and 4'b0011 otherwise.
- R7: A packet whose raster operation (control bits 23:16) is not 0xF0 makes no writes and still raises `done`.
- R8: An empty rectangle (x2 ≤ x1 or y2 ≤ y1, unsigned) makes no writes. `done` is raised two cycles after the cycle in which the sixth word is accepted.
- R9: A 4-byte packet with both lane enables clear makes no writes and completes like an empty rectangle. No write is ever issued with an all-zero `wr_be`.
- R10: `done` is high for exactly one cycle: the cycle after the final write is accepted. It is never high together with `wr_valid`.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_be` hold their values into the next cycle.
- R12: After reset, `in_ready` is high, and `wr_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet word valid |
| in_ready | output | 1 | Engine accepts a packet word |
| in_data | input | 32 | Packet word |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Word-aligned byte address |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Byte-lane enables |
| done | output | 1 | One-cycle end-of-packet pulse |

## Verification
A corrupt x or y counter shows up at once as a wrong `wr_addr` on the very next accepted write. A slip at a row boundary shows up as a repeated or missing row address, or as a `done` arriving early or late against the count of accepted writes. A wrong latched mode bit shows up on the first write of the packet, as wrong lane enables or unreplicated data. A stuck walker state shows up within one cycle as `done` lasting more than a cycle or `in_ready` rising while writes are still pending.

// File: rtl/rfill_pkg.sv
package rfill_pkg;

    localparam int WORD_W   = 32;
    localparam int COORD_W  = 16;
    localparam int LANES    = WORD_W / 8;
    localparam int PKT_LEN  = 6;
    localparam logic [7:0] ROP_REPLACE = 8'hF0;

    typedef struct packed {
        logic               lo_en;
        logic               hi_en;
        logic               tiled;
        logic               wide;
        logic [7:0]         rop;
        logic [COORD_W-1:0] pitch;
        logic [COORD_W-1:0] x1;
        logic [COORD_W-1:0] y1;
        logic [COORD_W-1:0] x2;
        logic [COORD_W-1:0] y2;
        logic [WORD_W-1:0]  base;
        logic [WORD_W-1:0]  fill;
    } fill_job_t;

    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_RUN  = 2'd1,
        WALK_FIN  = 2'd2
    } walk_state_t;

    // A job makes no writes at all when any of these hold
    function automatic logic job_skips(fill_job_t j);
        logic empty;
        empty = (j.x2 <= j.x1) || (j.y2 <= j.y1);
        return empty || (j.rop != ROP_REPLACE) || (j.wide && !j.lo_en && !j.hi_en);
    endfunction

    function automatic logic [LANES-1:0] lane_mask(fill_job_t j, logic upper_half);
        if (j.wide)
            return {j.hi_en, {(LANES-1){j.lo_en}}};
        else
            return upper_half ? {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}}
                              : {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}};
    endfunction

    function automatic logic [WORD_W-1:0] lane_data(fill_job_t j);
        if (j.wide)
            return j.fill;
        else
            return {2{j.fill[WORD_W/2-1:0]}};
    endfunction

endpackage

// File: rtl/rfill_intake.sv
module rfill_intake
    import rfill_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              start,
    output fill_job_t         job
);
    localparam int IDX_W = $clog2(PKT_LEN);

    logic [IDX_W-1:0] idx_q;
    logic             start_q;
    fill_job_t        job_q;
    logic             take;

    assign in_ready = !hold && !start_q;
    assign take     = in_valid && in_ready;
    assign start    = start_q;
    assign job      = job_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            start_q <= 1'b0;
            job_q   <= '0;
        end else begin
            start_q <= 1'b0;
            if (take) begin
                case (idx_q)
                    IDX_W'(0): begin
                        job_q.lo_en <= in_data[0];
                        job_q.hi_en <= in_data[1];
                        job_q.tiled <= in_data[2];
                    end
                    IDX_W'(1): begin
                        job_q.pitch <= in_data[COORD_W-1:0];
                        job_q.rop   <= in_data[23:16];
                        job_q.wide  <= in_data[25];
                    end
                    IDX_W'(2): begin
                        job_q.x1 <= in_data[COORD_W-1:0];
                        job_q.y1 <= in_data[WORD_W-1:COORD_W];
                    end
                    IDX_W'(3): begin
                        job_q.x2 <= in_data[COORD_W-1:0];
                        job_q.y2 <= in_data[WORD_W-1:COORD_W];
                    end
                    IDX_W'(4): job_q.base <= in_data;
                    default:   job_q.fill <= in_data;
                endcase
                if (idx_q == IDX_W'(PKT_LEN - 1)) begin
                    idx_q   <= '0;
                    start_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rfill_addr.sv
module rfill_addr
    import rfill_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  fill_job_t          job,
    input  logic [COORD_W-1:0] px,
    input  logic [COORD_W-1:0] py,
    output logic [ADDR_W-1:0]  byte_addr
);
    localparam int PB_W = COORD_W + 2;

    logic [PB_W-1:0]   pitch_bytes;
    logic [ADDR_W-1:0] row_off;
    logic [ADDR_W-1:0] col_off;

    always_comb begin
        pitch_bytes = job.tiled ? {job.pitch, 2'b00} : PB_W'(job.pitch);
        row_off     = ADDR_W'(py) * ADDR_W'(pitch_bytes);
        col_off     = job.wide ? (ADDR_W'(px) << 2) : (ADDR_W'(px) << 1);
        byte_addr   = ADDR_W'(job.base) + row_off + col_off;
    end
endmodule

// File: rtl/rfill_walker.sv
module rfill_walker
    import rfill_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  fill_job_t         job,
    output logic              busy,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [LANES-1:0]  wr_be,
    output logic              done
);
    walk_state_t        state_q;
    logic [COORD_W-1:0] cur_x, cur_y;
    logic [COORD_W:0]   nxt_x, nxt_y;
    logic               row_end, last_px;
    logic [ADDR_W-1:0]  byte_addr;

    rfill_addr #(.ADDR_W(ADDR_W)) u_addr (
        .job       (job),
        .px        (cur_x),
        .py        (cur_y),
        .byte_addr (byte_addr)
    );

    always_comb begin
        nxt_x   = {1'b0, cur_x} + 1'b1;
        nxt_y   = {1'b0, cur_y} + 1'b1;
        row_end = (nxt_x == {1'b0, job.x2});
        last_px = row_end && (nxt_y == {1'b0, job.y2});
    end

    assign busy     = (state_q != WALK_IDLE);
    assign wr_valid = (state_q == WALK_RUN);
    assign done     = (state_q == WALK_FIN);
    assign wr_addr  = {byte_addr[ADDR_W-1:2], 2'b00};
    assign wr_data  = lane_data(job);
    assign wr_be    = lane_mask(job, byte_addr[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WALK_IDLE;
            cur_x   <= '0;
            cur_y   <= '0;
        end else begin
            case (state_q)
                WALK_IDLE: if (start) begin
                    cur_x   <= job.x1;
                    cur_y   <= job.y1;
                    state_q <= job_skips(job) ? WALK_FIN : WALK_RUN;
                end
                WALK_RUN: if (wr_ready) begin
                    if (last_px) begin
                        state_q <= WALK_FIN;
                    end else if (row_end) begin
                        cur_x <= job.x1;
                        cur_y <= nxt_y[COORD_W-1:0];
                    end else begin
                        cur_x <= nxt_x[COORD_W-1:0];
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
    import rfill_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [LANES-1:0]  wr_be,
    output logic              done
);
    logic      start, busy;
    fill_job_t job;

    rfill_intake u_intake (
        .clk      (clk),
        .rst      (rst),
        .hold     (busy),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .start    (start),
        .job      (job)
    );

    rfill_walker #(.ADDR_W(ADDR_W)) u_walker (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .job      (job),
        .busy     (busy),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .done     (done)
    );
endmodule

// File: rtl/rfill_checker.sv
module rfill_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [3:0]        wr_be,
    input logic              done
);
    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_valid);

    // R1
    intake_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !in_ready);

    // R3
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[1:0] == 2'b00));

    // R9
    lanes_live_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_be != 4'b0000));
endmodule

bind rect_fill_engine rfill_checker #(.ADDR_W(ADDR_W)) u_rfill_chk (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .done     (done)
);

// File: tb/tb_rect_fill_engine.sv
`timescale 1ns/1ps
module tb_rect_fill_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic        done;

    always #2.5 clk = ~clk;

    rect_fill_engine #(.ADDR_W(32)) dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .done(done)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_xfer_cyc = 0;
    int acc_cyc = 0;
    int unsigned q_addr[$];
    int unsigned q_data[$];
    int unsigned q_be[$];
    logic [7:0]  lfsr = 8'h5A;
    logic        stall_prev = 1'b0;
    logic [31:0] s_addr, s_data;
    logic [3:0]  s_be;

    task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Memory-side reference monitor, evaluated every cycle
    always @(negedge clk) begin
        if (!rst) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            wr_ready = lfsr[0] | lfsr[2];
            if (stall_prev) begin
                check(wr_valid && wr_addr == s_addr && wr_data == s_data && wr_be == s_be,
                      "R11 held", wr_addr, s_addr);
            end
            if (wr_valid) begin
                check(!in_ready, "R1 ready low while writing", in_ready, 0);
            end
            if (wr_valid && wr_ready) begin
                if (q_addr.size() == 0) begin
                    check(1'b0, "R2 unexpected write", wr_addr, 0);
                end else begin
                    int unsigned ea, ed, eb;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    eb = q_be.pop_front();
                    check(wr_addr == ea, "R3 address", wr_addr, ea);
                    check(wr_data == ed, "R5/R6 data", wr_data, ed);
                    check(wr_be == 4'(eb), "R5/R6 lanes", wr_be, eb);
                end
                last_xfer_cyc = cyc;
            end
            stall_prev = wr_valid && !wr_ready;
            s_addr = wr_addr; s_data = wr_data; s_be = wr_be;
        end
    end

    task automatic build(input logic [31:0] cmd, ctrl, tl, br, base, fill);
        int unsigned pb, x1, y1, x2, y2, a, bpp;
        bit wide, lo, hi;
        lo = cmd[0]; hi = cmd[1];
        wide = ctrl[25];
        pb = cmd[2] ? ctrl[15:0] * 4 : ctrl[15:0];
        bpp = wide ? 4 : 2;
        x1 = tl[15:0]; y1 = tl[31:16]; x2 = br[15:0]; y2 = br[31:16];
        if (ctrl[23:16] != 8'hF0) return;
        if (wide && !lo && !hi) return;
        for (int y = int'(y1); y < int'(y2); y++) begin
            for (int x = int'(x1); x < int'(x2); x++) begin
                a = base + int'(y) * pb + int'(x) * bpp;
                q_addr.push_back(a & 32'hFFFF_FFFC);
                if (wide) begin
                    q_data.push_back(fill);
                    q_be.push_back({hi, lo, lo, lo});
                end else begin
                    q_data.push_back({fill[15:0], fill[15:0]});
                    q_be.push_back(a[1] ? 4'b1100 : 4'b0011);
                end
            end
        end
    endtask

    task automatic push(input logic [31:0] w);
        in_data = w;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        acc_cyc = cyc;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_pkt(input logic [31:0] cmd, ctrl, tl, br, base, fill, input string tag);
        int n, guard;
        build(cmd, ctrl, tl, br, base, fill);
        n = q_addr.size();
        push(cmd); push(ctrl); push(tl); push(br); push(base); push(fill);
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(done, {tag, " R10 done seen"}, done, 1);
        if (n == 0)
            check(cyc == acc_cyc + 2, {tag, " R8 done timing"}, cyc, acc_cyc + 2);
        else
            check(cyc == last_xfer_cyc + 1, {tag, " R10 done after last write"}, cyc, last_xfer_cyc + 1);
        check(q_addr.size() == 0, {tag, " R2 all pixels written"}, q_addr.size(), 0);
        @(negedge clk);
        check(!done, {tag, " R10 done single"}, done, 0);
        check(in_ready, {tag, " R1 ready again"}, in_ready, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R12
        check(in_ready, "R12 ready after reset", in_ready, 1);
        check(!wr_valid, "R12 no write after reset", wr_valid, 0);
        check(!done, "R12 no done after reset", done, 0);
        // R2 R3 R5: 4-byte, both lane groups
        run_pkt(32'h3, 32'h02F0_0040, {16'd1, 16'd2}, {16'd3, 16'd5}, 32'h1000, 32'hA1B2C3D4, "R5 both");
        // R5: stencil byte only
        run_pkt(32'h2, 32'h02F0_0020, {16'd0, 16'd0}, {16'd2, 16'd2}, 32'h2000, 32'h7F00_0000, "R5 top");
        // R5: depth bits only
        run_pkt(32'h1, 32'h02F0_0020, {16'd4, 16'd1}, {16'd5, 16'd4}, 32'h2000, 32'h00FF_FFFF, "R5 low");
        // R6: 2-byte, odd start x
        run_pkt(32'h0, 32'h00F0_000A, {16'd2, 16'd1}, {16'd4, 16'd4}, 32'h3000, 32'hDEAD_BEEF, "R6 half");
        // R4: tiled, pitch in 4-byte units
        run_pkt(32'h7, 32'h02F0_0010, {16'd1, 16'd3}, {16'd3, 16'd5}, 32'h4000, 32'h1234_5678, "R4 tiled");
        // R8: empty in x and in y
        run_pkt(32'h3, 32'h02F0_0040, {16'd2, 16'd5}, {16'd6, 16'd5}, 32'h1000, 32'h1, "R8 empty x");
        run_pkt(32'h3, 32'h02F0_0040, {16'd6, 16'd1}, {16'd2, 16'd4}, 32'h1000, 32'h1, "R8 empty y");
        // R7: other raster operation
        run_pkt(32'h3, 32'h02CC_0040, {16'd0, 16'd0}, {16'd2, 16'd2}, 32'h1000, 32'h1, "R7 rop");
        // R9: 4-byte with no lanes enabled
        run_pkt(32'h4, 32'h02F0_0040, {16'd0, 16'd0}, {16'd2, 16'd2}, 32'h1000, 32'h1, "R9 nolanes");
        // R2: single pixel and single row
        run_pkt(32'h3, 32'h02F0_0100, {16'd7, 16'd9}, {16'd8, 16'd10}, 32'h0, 32'h55AA_55AA, "R2 one");
        run_pkt(32'h0, 32'h00F0_0100, {16'd0, 16'd1}, {16'd1, 16'd6}, 32'h6002, 32'h0000_9999, "R2 row");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule